// File: doc/BRIEF.md
# Word-wide Arithmetic and Logic Unit with Overflow Flag

This block computes one arithmetic or bitwise operation on two operands of one machine word. Its outputs are a result word, a flag that shows the result is all zeros, and a flag that shows two's-complement overflow. It has no state. A single-cycle datapath places it between the register read ports and the write-back and memory-address paths. The registers downstream capture its outputs on the next clock edge. The zero flag drives the branch-if-equal decision.

A 4-bit select picks one of ten operations. The select chooses between signed and unsigned forms of addition, subtraction and less-than comparison. It also chooses four bitwise functions. Only the signed add and the signed subtract report overflow. The signed comparison gives the mathematically correct answer even when the internal difference overflows. A select code outside the defined set forces the result and the overflow flag low. The adder can be built as an explicit bit-serial carry chain or as a plain `+` expression, chosen by a parameter.

Top module: `wordalu`

## Requirements
- R1: Select 4'h0 (signed add) and 4'h1 (unsigned add) give result = A + B modulo 2^32.
- R2: Select 4'h2 (signed subtract) and 4'h3 (unsigned subtract) give result = A − B modulo 2^32.
- R3: Select 4'h4 gives A AND B, 4'h5 gives A OR B, 4'h6 gives A XOR B, and 4'h7 gives NOT (A OR B).
- R4: Select 4'h8 gives 32'd1 when A < B as two's-complement numbers, and 32'd0 otherwise. This holds even when A − B overflows.
- R5: Select 4'h9 gives 32'd1 when A < B as unsigned numbers, and 32'd0 otherwise.
- R6: The zero output is 1 exactly when all 32 result bits are 0, for every select value.
- R7: Under select 4'h0, overflow is 1 exactly when A and B have the same sign bit (bit 31) and the result's sign bit differs from it.
- R8: Under select 4'h2, overflow is 1 exactly when A and B differ in bit 31 and the result's bit 31 differs from A's.
- R9: Under selects 4'h1, 4'h3 and 4'h4 through 4'h9, overflow is 0 for all operands. This includes unsigned wrap-around and comparisons whose internal difference overflows.
- R10: A select from 4'hA to 4'hF gives result 0 and overflow 0, so zero reads 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Operation select (encodings in R1–R5, R10) |
| opnd_a | input | 32 | First operand A |
| opnd_b | input | 32 | Second operand B |
| result | output | 32 | Computed result word |
| zero | output | 1 | High when result is all zeros |
| ovf | output | 1 | Signed overflow for signed add and subtract only |

## Verification
The zero flag and the overflow flag can both be high for the same operand pair. The signed comparison and an internal overflow can also fall together. Adding 0x80000000 to itself is one such case: the stored word wraps to zero while the signed sum overflows. The bench drives such pairs and requires both flags at once. It also drives comparisons such as the most negative value against a positive one. There the wrapped difference has the wrong sign, and the bench requires the correct less-than answer with overflow kept low. Each expected value comes from 64-bit arithmetic in the bench, not from sign-bit rules.

// File: rtl/wordalu_pkg.sv
package wordalu_pkg;

   localparam int unsigned SEL_W = 4;

   typedef enum logic [SEL_W-1:0] {
      OP_ADD  = 4'h0,
      OP_ADDU = 4'h1,
      OP_SUB  = 4'h2,
      OP_SUBU = 4'h3,
      OP_AND  = 4'h4,
      OP_OR   = 4'h5,
      OP_XOR  = 4'h6,
      OP_NOR  = 4'h7,
      OP_SLT  = 4'h8,
      OP_SLTU = 4'h9
   } alu_op_e;

   typedef enum logic [2:0] {
      SRC_SUM,
      SRC_AND,
      SRC_OR,
      SRC_XOR,
      SRC_NOR,
      SRC_SLT,
      SRC_SLTU,
      SRC_NONE
   } res_src_e;

   typedef enum logic [1:0] {
      BITOP_AND,
      BITOP_OR,
      BITOP_XOR,
      BITOP_NOR
   } bitop_e;

   typedef struct packed {
      logic     negate_b;
      logic     ovf_en;
      res_src_e src;
   } alu_ctl_t;

endpackage

// File: rtl/wordalu_decode.sv
module wordalu_decode
   import wordalu_pkg::*;
(
   input  logic [SEL_W-1:0] op_sel,
   output alu_ctl_t         ctl
);

   always_comb begin
      ctl = '{negate_b: 1'b0, ovf_en: 1'b0, src: SRC_NONE};
      case (op_sel)
         OP_ADD:  ctl = '{negate_b: 1'b0, ovf_en: 1'b1, src: SRC_SUM};
         OP_ADDU: ctl = '{negate_b: 1'b0, ovf_en: 1'b0, src: SRC_SUM};
         OP_SUB:  ctl = '{negate_b: 1'b1, ovf_en: 1'b1, src: SRC_SUM};
         OP_SUBU: ctl = '{negate_b: 1'b1, ovf_en: 1'b0, src: SRC_SUM};
         OP_AND:  ctl = '{negate_b: 1'b0, ovf_en: 1'b0, src: SRC_AND};
         OP_OR:   ctl = '{negate_b: 1'b0, ovf_en: 1'b0, src: SRC_OR};
         OP_XOR:  ctl = '{negate_b: 1'b0, ovf_en: 1'b0, src: SRC_XOR};
         OP_NOR:  ctl = '{negate_b: 1'b0, ovf_en: 1'b0, src: SRC_NOR};
         OP_SLT:  ctl = '{negate_b: 1'b1, ovf_en: 1'b0, src: SRC_SLT};
         OP_SLTU: ctl = '{negate_b: 1'b1, ovf_en: 1'b0, src: SRC_SLTU};
         default: ctl = '{negate_b: 1'b0, ovf_en: 1'b0, src: SRC_NONE};
      endcase
   end

endmodule

// File: rtl/wordalu_adder.sv
module wordalu_adder #(
   parameter int unsigned WIDTH      = 32,
   parameter bit          RIPPLE_ADD = 1'b1
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             negate_b,
   output logic [WIDTH-1:0] sum,
   output logic             carry_out,
   output logic             sgn_ovf
);

   localparam int unsigned MSB = WIDTH - 1;

   logic [WIDTH-1:0] b_eff;

   assign b_eff = negate_b ? ~b : b;

   generate
      if (RIPPLE_ADD) begin : g_ripple
         always_comb begin
            logic cy;
            cy  = negate_b;
            sum = '0;
            for (int i = 0; i < int'(WIDTH); i++) begin
               sum[i] = a[i] ^ b_eff[i] ^ cy;
               cy     = (a[i] & b_eff[i]) | (cy & (a[i] ^ b_eff[i]));
            end
            carry_out = cy;
         end
      end else begin : g_flat
         logic [WIDTH:0] wide;
         assign wide      = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, negate_b};
         assign sum       = wide[WIDTH-1:0];
         assign carry_out = wide[WIDTH];
      end
   endgenerate

   // Same-sign inputs to the effective adder with a differently signed sum.
   assign sgn_ovf = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);

endmodule

// File: rtl/wordalu_bitops.sv
module wordalu_bitops
   import wordalu_pkg::*;
#(
   parameter int unsigned WIDTH = 32
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  bitop_e           fn,
   output logic [WIDTH-1:0] y
);

   always_comb begin
      unique case (fn)
         BITOP_AND: y = a & b;
         BITOP_OR:  y = a | b;
         BITOP_XOR: y = a ^ b;
         BITOP_NOR: y = ~(a | b);
         default:   y = '0;
      endcase
   end

endmodule

// File: rtl/wordalu_compare.sv
module wordalu_compare #(
   parameter int unsigned WIDTH = 32
) (
   input  logic [WIDTH-1:0] diff,
   input  logic             carry_out,
   input  logic             diff_ovf,
   output logic             lt_signed,
   output logic             lt_unsigned
);

   // The sign of the difference is wrong exactly when it overflowed.
   assign lt_signed   = diff[WIDTH-1] ^ diff_ovf;
   // No carry out of A + ~B + 1 means a borrow, so A < B as unsigned.
   assign lt_unsigned = ~carry_out;

endmodule

// File: rtl/wordalu.sv
module wordalu
   import wordalu_pkg::*;
#(
   parameter int unsigned WIDTH      = 32,
   parameter bit          RIPPLE_ADD = 1'b1
) (
   input  logic [3:0]       op_sel,
   input  logic [WIDTH-1:0] opnd_a,
   input  logic [WIDTH-1:0] opnd_b,
   output logic [WIDTH-1:0] result,
   output logic             zero,
   output logic             ovf
);

   localparam logic [WIDTH-1:0] ONE_W = {{(WIDTH-1){1'b0}}, 1'b1};

   generate
      if (WIDTH < 2) begin : g_width_bad
         $error("wordalu: WIDTH must be at least 2");
      end
      if (SEL_W != 4) begin : g_sel_bad
         $error("wordalu: select width must be 4");
      end
   endgenerate

   alu_ctl_t         ctl;
   logic [WIDTH-1:0] sum;
   logic             carry_out;
   logic             sgn_ovf;
   logic [WIDTH-1:0] bit_y;
   bitop_e           bit_fn;
   logic             lt_s;
   logic             lt_u;

   wordalu_decode u_decode (
      .op_sel (op_sel),
      .ctl    (ctl)
   );

   wordalu_adder #(
      .WIDTH      (WIDTH),
      .RIPPLE_ADD (RIPPLE_ADD)
   ) u_adder (
      .a         (opnd_a),
      .b         (opnd_b),
      .negate_b  (ctl.negate_b),
      .sum       (sum),
      .carry_out (carry_out),
      .sgn_ovf   (sgn_ovf)
   );

   always_comb begin
      case (ctl.src)
         SRC_OR:  bit_fn = BITOP_OR;
         SRC_XOR: bit_fn = BITOP_XOR;
         SRC_NOR: bit_fn = BITOP_NOR;
         default: bit_fn = BITOP_AND;
      endcase
   end

   wordalu_bitops #(.WIDTH(WIDTH)) u_bitops (
      .a  (opnd_a),
      .b  (opnd_b),
      .fn (bit_fn),
      .y  (bit_y)
   );

   wordalu_compare #(.WIDTH(WIDTH)) u_compare (
      .diff        (sum),
      .carry_out   (carry_out),
      .diff_ovf    (sgn_ovf),
      .lt_signed   (lt_s),
      .lt_unsigned (lt_u)
   );

   always_comb begin
      case (ctl.src)
         SRC_SUM:  result = sum;
         SRC_AND,
         SRC_OR,
         SRC_XOR,
         SRC_NOR:  result = bit_y;
         SRC_SLT:  result = lt_s ? ONE_W : '0;
         SRC_SLTU: result = lt_u ? ONE_W : '0;
         default:  result = '0;
      endcase
   end

   assign zero = ~|result;
   assign ovf  = ctl.ovf_en & sgn_ovf;

endmodule

// File: rtl/wordalu_chk.sv
module wordalu_chk #(
   parameter int unsigned WIDTH = 32
) (
   input logic [3:0]       op_sel,
   input logic [WIDTH-1:0] opnd_a,
   input logic [WIDTH-1:0] opnd_b,
   input logic [WIDTH-1:0] result,
   input logic             zero,
   input logic             ovf
);

   localparam int unsigned MSB = WIDTH - 1;

   always_comb begin
      if (!$isunknown({op_sel, opnd_a, opnd_b})) begin
         // R7
         add_ovf_chk: assert (!(op_sel == 4'h0 && ovf) ||
                              (opnd_a[MSB] == opnd_b[MSB] && result[MSB] != opnd_a[MSB]))
            else $error("add overflow without sign condition");
         // R8
         sub_ovf_chk: assert (!(op_sel == 4'h2 && ovf) ||
                              (opnd_a[MSB] != opnd_b[MSB] && result[MSB] != opnd_a[MSB]))
            else $error("sub overflow without sign condition");
         // R9
         no_overflow_chk: assert (!ovf || op_sel == 4'h0 || op_sel == 4'h2)
            else $error("overflow on an unqualified select");
         // R4
         slt_shape_chk: assert (!(op_sel == 4'h8 || op_sel == 4'h9) || result[WIDTH-1:1] == '0)
            else $error("compare result wider than one bit");
         // R10
         undef_quiet_chk: assert (op_sel < 4'hA || (result == '0 && !ovf && zero))
            else $error("undefined select produced output");
         // R6
         sub_zero_chk: assert (!(op_sel == 4'h3) || (zero == (opnd_a == opnd_b)))
            else $error("zero flag disagrees with operand equality");
      end
   end

endmodule

bind wordalu wordalu_chk #(.WIDTH(WIDTH)) u_chk (
   .op_sel (op_sel),
   .opnd_a (opnd_a),
   .opnd_b (opnd_b),
   .result (result),
   .zero   (zero),
   .ovf    (ovf)
);

// File: tb/wordalu_tb.sv
module wordalu_tb;

   logic        clk = 1'b0;
   logic [3:0]  op_sel = 4'h0;
   logic [31:0] opnd_a = '0;
   logic [31:0] opnd_b = '0;
   logic [31:0] result;
   logic        zero;
   logic        ovf;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;
   logic [31:0] rng = 32'h1234_5678;

   always #2 clk = ~clk;

   wordalu u_dut (
      .op_sel (op_sel),
      .opnd_a (opnd_a),
      .opnd_b (opnd_b),
      .result (result),
      .zero   (zero),
      .ovf    (ovf)
   );

   function automatic void ref_model(input logic [3:0] op, input logic [31:0] a,
                                     input logic [31:0] b, output logic [31:0] r,
                                     output logic v);
      longint sa = longint'($signed(a));
      longint sb = longint'($signed(b));
      longint s;
      longint ua = longint'({32'b0, a});
      longint ub = longint'({32'b0, b});
      r = '0;
      v = 1'b0;
      case (op)
         4'h0: begin s = sa + sb; r = s[31:0]; v = (s > 64'sd2147483647) || (s < -64'sd2147483648); end
         4'h1: begin s = ua + ub; r = s[31:0]; end
         4'h2: begin s = sa - sb; r = s[31:0]; v = (s > 64'sd2147483647) || (s < -64'sd2147483648); end
         4'h3: begin s = ua - ub; r = s[31:0]; end
         4'h4: r = a & b;
         4'h5: r = a | b;
         4'h6: r = a ^ b;
         4'h7: r = ~(a | b);
         4'h8: r = (sa < sb) ? 32'd1 : 32'd0;
         4'h9: r = (ua < ub) ? 32'd1 : 32'd0;
         default: begin r = '0; v = 1'b0; end
      endcase
   endfunction

   task automatic check(input string req, input string what,
                        input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
      end
   endtask

   // Drive on a falling edge, sample one nanosecond after the next rising edge.
   task automatic apply(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
      @(negedge clk);
      op_sel = op;
      opnd_a = a;
      opnd_b = b;
      @(posedge clk);
      #1;
   endtask

   task automatic run_one(input string req, input logic [3:0] op,
                          input logic [31:0] a, input logic [31:0] b);
      logic [31:0] er;
      logic        ev;
      apply(op, a, b);
      ref_model(op, a, b, er, ev);
      check(req, "result", result, er);
      check("R6", "zero", {31'b0, zero}, {31'b0, er == 32'd0});
      check(req, "ovf", {31'b0, ovf}, {31'b0, ev});
   endtask

   task automatic t_idle();
      @(posedge clk);
      #1;
      check("R1", "idle result", result, 32'd0);
      check("R6", "idle zero", {31'b0, zero}, 32'd1);
      check("R7", "idle ovf", {31'b0, ovf}, 32'd0);
   endtask

   task automatic t_add();
      run_one("R1", 4'h0, 32'd5, 32'd7);
      run_one("R7", 4'h0, 32'h7FFF_FFFF, 32'd1);
      run_one("R7", 4'h0, 32'h8000_0000, 32'hFFFF_FFFF);
      run_one("R7", 4'h0, 32'h8000_0000, 32'h8000_0000);
      check("R7", "zero with ovf", {30'b0, zero, ovf}, 32'd3);
      run_one("R7", 4'h0, 32'h7FFF_FFFF, 32'h8000_0000);
      run_one("R1", 4'h1, 32'hFFFF_FFFF, 32'd1);
      run_one("R9", 4'h1, 32'h7FFF_FFFF, 32'd1);
   endtask

   task automatic t_sub();
      run_one("R2", 4'h2, 32'd10, 32'd3);
      run_one("R8", 4'h2, 32'h8000_0000, 32'd1);
      run_one("R8", 4'h2, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
      run_one("R8", 4'h2, 32'h8000_0000, 32'h8000_0000);
      run_one("R2", 4'h3, 32'd0, 32'd1);
      run_one("R9", 4'h3, 32'h8000_0000, 32'd1);
   endtask

   task automatic t_logic();
      for (int op = 4; op < 8; op++) begin
         run_one("R3", op[3:0], 32'hF0F0_A5A5, 32'h0FF0_5A0F);
         run_one("R3", op[3:0], 32'hFFFF_FFFF, 32'hFFFF_FFFF);
         run_one("R3", op[3:0], 32'h0, 32'h0);
      end
   endtask

   task automatic t_slt();
      run_one("R4", 4'h8, 32'hFFFF_FFFF, 32'd1);
      run_one("R4", 4'h8, 32'h8000_0000, 32'h7FFF_FFFF);
      run_one("R4", 4'h8, 32'h7FFF_FFFF, 32'h8000_0000);
      run_one("R4", 4'h8, 32'd3, 32'd3);
      run_one("R9", 4'h8, 32'h8000_0000, 32'd1);
   endtask

   task automatic t_sltu();
      run_one("R5", 4'h9, 32'hFFFF_FFFF, 32'd1);
      run_one("R5", 4'h9, 32'd1, 32'hFFFF_FFFF);
      run_one("R5", 4'h9, 32'd9, 32'd9);
      run_one("R5", 4'h9, 32'd0, 32'd1);
   endtask

   task automatic t_undef();
      for (int op = 10; op < 16; op++) begin
         run_one("R10", op[3:0], 32'h7FFF_FFFF, 32'd1);
         check("R10", "zero", {31'b0, zero}, 32'd1);
      end
   endtask

   task automatic t_sweep();
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] a;
         logic [31:0] b;
         rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
         a = rng;
         rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
         b = (i % 7 == 0) ? a : rng;
         run_one("R6", rng[3:0], a, b);
      end
   endtask

   initial begin
      #200000;
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      t_idle();
      t_add();
      t_sub();
      t_logic();
      t_slt();
      t_sltu();
      t_undef();
      t_sweep();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule